// File: doc/BRIEF.md
# ADC Result Limit Alarm with Fault Filtering and Release Band

This block checks the conversion results of one ADC channel against a programmed upper and lower limit. It does not trip on a single stray sample. A result is a fault when it lies strictly above the upper limit or strictly below the lower limit. The alarm sets only after a programmed number of faults arrive back to back, and any result inside the limits starts the count again.

Once set, the alarm stays latched. It is released only by a result that has come back inside the limits by at least a programmed hysteresis margin on both sides. This stops the flag from chattering when a signal sits close to a limit.

Every valid result that is a fault also produces a one-cycle fault pulse. The limit, hysteresis and fault-count values come from configuration storage outside the block. For reference, that storage typically holds a hysteresis of 8 codes and a count setting of 0 after reset.

Top module: `adc_limit_alarm`

## Requirements
- R1: A valid result is a fault when it is strictly greater than `limitHigh` or strictly less than `limitLow`; a result equal to either limit is not a fault.
- R2: `alarm` rises in the cycle after the valid result that completes a run of `faultCountSel + 1` consecutive faults, where `faultCountSel` is a 3-bit field (0 means a single fault, 7 means eight).
- R3: Any valid result that is not a fault resets the consecutive-fault run to zero, so a new trip again needs the full number of faults.
- R4: While faults continue after the trip, `alarm` stays high; the run count saturates and does not wrap.
- R5: While `alarm` is high, a valid result with `limitLow + hyst <= result <= limitHigh - hyst`, where `hyst` is a 7-bit code count, clears `alarm` in the following cycle.
- R6: While `alarm` is high, a valid result that is within the limits but closer than `hyst` codes to either limit leaves `alarm` set.
- R7: When `resultValid` is low, `alarm` and the run count do not change and `faultPulse` is low in the next cycle.
- R8: A synchronous `rst` clears `alarm`, `faultPulse` and the run count in the next cycle.
- R9: The release bounds are computed without wrap-around; when `limitHigh < hyst`, or when `limitHigh - hyst < limitLow + hyst`, no result can release the alarm.
- R10: `faultPulse` is high for exactly the cycle after each valid fault result and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| resultValid | input | 1 | Strobe marking a new ADC result |
| result | input | 12 | Unsigned ADC result |
| limitHigh | input | 12 | Upper limit, inclusive in range |
| limitLow | input | 12 | Lower limit, inclusive in range |
| hyst | input | 7 | Release margin in codes |
| faultCountSel | input | 3 | Consecutive faults to trip, minus one |
| alarm | output | 1 | Latched alarm flag |
| faultPulse | output | 1 | One-cycle pulse per faulty result |

## Verification
Results placed exactly on each limit and one code past it tell an inclusive comparison from a strict one. Fault runs broken one short of the trip count show whether an in-range result really restarts the count.

Release is probed at each hysteresis bound and one code inside it, with a high limit below the margin added to expose wrap-around. Gaps in the valid strobe are mixed into a long random stream. There every cycle is compared against a behavioural model, which exposes any update that happens without a strobe.

// File: rtl/adc_alarm_pkg.sv
package adc_alarm_pkg;

  // Strobes passed from the comparison datapath to the alarm control
  typedef struct packed {
    logic overHigh;    // result strictly above upper limit
    logic underLow;    // result strictly below lower limit
    logic releaseOk;   // result inside both limits by the hysteresis margin
  } cmpStrobes_t;

endpackage

// File: rtl/adc_alarm_cmp.sv
module adc_alarm_cmp
  import adc_alarm_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int HYST_W = 7
) (
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] limitHigh,
  input  logic [DATA_W-1:0] limitLow,
  input  logic [HYST_W-1:0] hyst,
  output cmpStrobes_t       strobes
);

  // One extra bit so neither release bound wraps
  localparam int EXT_W = (DATA_W > HYST_W ? DATA_W : HYST_W) + 1;

  logic [EXT_W-1:0] resultExt;
  logic [EXT_W-1:0] highExt;
  logic [EXT_W-1:0] lowExt;
  logic [EXT_W-1:0] hystExt;
  logic [EXT_W-1:0] lowBound;
  logic [EXT_W-1:0] resultPlusHyst;

  always_comb begin
    resultExt      = EXT_W'(result);
    highExt        = EXT_W'(limitHigh);
    lowExt         = EXT_W'(limitLow);
    hystExt        = EXT_W'(hyst);
    lowBound       = lowExt + hystExt;
    resultPlusHyst = resultExt + hystExt;

    strobes.overHigh  = resultExt > highExt;
    strobes.underLow  = resultExt < lowExt;
    // result <= high - hyst rewritten as result + hyst <= high
    strobes.releaseOk = (resultPlusHyst <= highExt) && (resultExt >= lowBound);
  end

endmodule

// File: rtl/adc_alarm_ctrl.sv
module adc_alarm_ctrl
  import adc_alarm_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resultValid,
  input  logic [CNT_W-1:0] faultCountSel,
  input  cmpStrobes_t      strobes,
  output logic             alarm,
  output logic             faultPulse
);

  localparam int RUN_W = CNT_W + 1;

  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] tripCnt;
  logic [RUN_W-1:0] runNext;
  logic             isFault;
  logic             tripNow;

  always_comb begin
    tripCnt = RUN_W'(faultCountSel) + RUN_W'(1);
    isFault = strobes.overHigh | strobes.underLow;
    runNext = (runCnt >= tripCnt) ? tripCnt : runCnt + RUN_W'(1);
    tripNow = isFault && (runNext >= tripCnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt     <= '0;
      alarm      <= 1'b0;
      faultPulse <= 1'b0;
    end else begin
      faultPulse <= resultValid & isFault;
      if (resultValid) begin
        if (isFault) begin
          runCnt <= runNext;
          if (tripNow) alarm <= 1'b1;
        end else begin
          runCnt <= '0;
          if (strobes.releaseOk) alarm <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/adc_limit_alarm.sv
module adc_limit_alarm
  import adc_alarm_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int HYST_W = 7,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              resultValid,
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] limitHigh,
  input  logic [DATA_W-1:0] limitLow,
  input  logic [HYST_W-1:0] hyst,
  input  logic [CNT_W-1:0]  faultCountSel,
  output logic              alarm,
  output logic              faultPulse
);

  cmpStrobes_t cmpStrobes;

  adc_alarm_cmp #(.DATA_W(DATA_W), .HYST_W(HYST_W)) cmp_i (
    .result    (result),
    .limitHigh (limitHigh),
    .limitLow  (limitLow),
    .hyst      (hyst),
    .strobes   (cmpStrobes)
  );

  adc_alarm_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .resultValid   (resultValid),
    .faultCountSel (faultCountSel),
    .strobes       (cmpStrobes),
    .alarm         (alarm),
    .faultPulse    (faultPulse)
  );

endmodule

// File: rtl/adc_limit_alarm_chk.sv
module adc_limit_alarm_chk #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              resultValid,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] limitHigh,
  input logic [DATA_W-1:0] limitLow,
  input logic [CNT_W-1:0]  faultCountSel,
  input logic              alarm,
  input logic              faultPulse
);

  // R10: a pulse only follows a valid strobe
  assert_pulse_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
    faultPulse |-> $past(resultValid));

  // R2: the alarm only sets on the edge that also reports a fault
  assert_rise_with_fault_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> faultPulse);

  // R5: the alarm never clears on a fault result
  assert_fall_without_fault_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm) |-> !faultPulse);

  // R7: no strobe, no change
  assert_hold_without_valid_R7: assert property (@(posedge clk) disable iff (rst)
    !resultValid |=> ($stable(alarm) && !faultPulse));

  // R8: reset clears both outputs
  assert_reset_clears_R8: assert property (@(posedge clk)
    $past(rst) |-> (!alarm && !faultPulse));

  // R2: a count setting of zero trips on a single fault
  assert_single_fault_trip_R2: assert property (@(posedge clk) disable iff (rst)
    (resultValid && faultCountSel == '0 && (result > limitHigh || result < limitLow))
      |=> alarm);

endmodule

bind adc_limit_alarm adc_limit_alarm_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .resultValid   (resultValid),
  .result        (result),
  .limitHigh     (limitHigh),
  .limitLow      (limitLow),
  .faultCountSel (faultCountSel),
  .alarm         (alarm),
  .faultPulse    (faultPulse)
);

// File: tb/adc_limit_alarm_tb.sv
module adc_limit_alarm_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        resultValid = 1'b0;
  logic [11:0] result = '0;
  logic [11:0] limitHigh = 12'd3000;
  logic [11:0] limitLow = 12'd1000;
  logic [6:0]  hyst = 7'd8;
  logic [2:0]  faultCountSel = '0;
  logic        alarm;
  logic        faultPulse;

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    running = 1'b0;
  string curReq = "R8";

  // Reference model state
  int modelRun = 0;
  bit modelAlarm = 1'b0;
  bit modelPulse = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  adc_limit_alarm dut_i (
    .clk(clk), .rst(rst), .resultValid(resultValid), .result(result),
    .limitHigh(limitHigh), .limitLow(limitLow), .hyst(hyst),
    .faultCountSel(faultCountSel), .alarm(alarm), .faultPulse(faultPulse)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    int r, hi, lo, hy, trip;
    bit f;
    r = int'(result); hi = int'(limitHigh); lo = int'(limitLow);
    hy = int'(hyst); trip = int'(faultCountSel) + 1;
    if (rst) begin
      modelRun = 0; modelAlarm = 0; modelPulse = 0;
    end else if (resultValid) begin
      f = (r > hi) || (r < lo);
      modelPulse = f;
      if (f) begin
        modelRun = (modelRun + 1 > trip) ? trip : modelRun + 1;
        if (modelRun >= trip) modelAlarm = 1;
      end else begin
        modelRun = 0;
        if (modelAlarm && (r <= hi - hy) && (r >= lo + hy)) modelAlarm = 0;
      end
    end else begin
      modelPulse = 0;
    end
  end

  task automatic check(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (running) begin
      check(curReq, "alarm", alarm, modelAlarm);
      check(curReq, "faultPulse", faultPulse, modelPulse);
    end
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic sample(int value);
    @(negedge clk);
    resultValid = 1'b1;
    result = 12'(value);
    @(negedge clk);
    resultValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(2);
    rst = 1'b0;
    running = 1'b1;
    check("R8", "alarm after reset", alarm, 1'b0);

    // R1 / R2: limits are in range; one fault trips with setting 0
    curReq = "R1";
    sample(3000); check("R1", "upper limit not fault", faultPulse, 1'b0);
    sample(1000); check("R1", "lower limit not fault", faultPulse, 1'b0);
    curReq = "R2";
    sample(3001); check("R2", "single fault trips", alarm, 1'b1);
    check("R10", "pulse on fault", faultPulse, 1'b1);
    idle(1); check("R10", "pulse one cycle", faultPulse, 1'b0);

    // R5 / R6: release band with hyst 8 -> 1008..2992
    curReq = "R6";
    sample(2993); check("R6", "inside margin keeps alarm", alarm, 1'b1);
    curReq = "R5";
    sample(2992); check("R5", "upper release bound clears", alarm, 1'b0);
    sample(999);
    curReq = "R6";
    sample(1007); check("R6", "lower margin keeps alarm", alarm, 1'b1);
    curReq = "R5";
    sample(1008); check("R5", "lower release bound clears", alarm, 1'b0);

    // R3: run broken one short of the trip count of 4
    curReq = "R3";
    faultCountSel = 3'd3;
    for (int i = 0; i < 3; i++) sample(4000);
    sample(2000);
    for (int i = 0; i < 3; i++) sample(10);
    check("R3", "restarted run not tripped", alarm, 1'b0);
    sample(10); check("R3", "fourth fault trips", alarm, 1'b1);

    // R4: continued faults keep the alarm, eight-fault setting
    curReq = "R4";
    for (int i = 0; i < 12; i++) sample(4095);
    check("R4", "alarm stays set", alarm, 1'b1);
    sample(2000); check("R4", "release after saturation", alarm, 1'b0);
    faultCountSel = 3'd7;
    for (int i = 0; i < 7; i++) sample(3500);
    check("R4", "seven of eight not tripped", alarm, 1'b0);
    sample(3500); check("R4", "eighth fault trips", alarm, 1'b1);

    // R7: results without strobe are ignored
    curReq = "R7";
    @(negedge clk); result = 12'd2000;
    idle(5); check("R7", "no release without strobe", alarm, 1'b1);
    sample(2000);
    result = 12'd4000;
    idle(12); check("R7", "no trip without strobe", alarm, 1'b0);

    // R9: high limit below margin, no release possible
    curReq = "R9";
    faultCountSel = 3'd0;
    limitHigh = 12'd5; limitLow = 12'd0;
    sample(6);
    for (int v = 0; v <= 5; v++) sample(v);
    check("R9", "no wrap release", alarm, 1'b1);
    limitHigh = 12'd100; limitLow = 12'd90;
    for (int v = 90; v <= 100; v++) sample(v);
    check("R9", "overlapping bounds hold", alarm, 1'b1);

    // R8: mid-run reset
    curReq = "R8";
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8", "reset clears alarm", alarm, 1'b0);

    // R2: random stream with strobe gaps, compared every cycle
    curReq = "R2";
    limitHigh = 12'd2500; limitLow = 12'd1500; hyst = 7'd40;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      resultValid = ($urandom_range(3) != 0);
      result = 12'($urandom_range(1300, 2700));
      faultCountSel = 3'($urandom_range(2));
    end
    @(negedge clk); resultValid = 1'b0;
    idle(2);

    running = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule